// File: doc/BRIEF.md
# Two-Channel Interleave Timing-Skew Calibrator

This block runs in the background beside a two-channel time-interleaved ADC and estimates the sampling-instant skew between the two channels. It sees one merged stream of signed samples with a valid strobe. The samples alternate between the channels, and the first valid sample after reset belongs to channel A. Two kinds of product are formed: a channel-A sample times the channel-B sample that follows it, and a channel-B sample times the channel-A sample that follows it. The sum of the first kind minus the sum of the second kind is a detector value. Its sign follows the sign of the skew, and it is zero when there is no skew.

Operation is duty-cycled to save power. A compute phase collects a fixed number of valid samples at full rate. One decision cycle then nudges a 6-bit delay-line control code up or down by one step, or leaves it alone. A rest phase of programmable length follows, and during it the arithmetic is idle and the code is frozen. The schedule repeats without end. The code drives the two channels' delay lines differentially, so skew of either sign can be cancelled. Offset and gain mismatch are assumed to be removed upstream.

Top module: `skew_cal_ctrl`

## Requirements
- R1: After synchronous reset, `code_o` is 32, `busy_o` is 1 (a compute phase starts at once) and `upd_o` is 0.
- R2: Valid samples alternate channel A, B, A, ... counted over every valid sample since reset, including samples that arrive during rest. Within one compute phase the detector D is the sum of (A sample × next B sample) minus the sum of (B sample × next A sample). Only pairs whose two samples both fall inside the same compute phase contribute.
- R3: The detector is exact for full-scale inputs (-512 and +511) over a whole window, with no wraparound.
- R4: A compute phase ends after exactly WIN_LEN valid samples; cycles with the strobe low do not count. `busy_o` is 1 through compute and the decision cycle, and 0 from the cycle in which the new code appears.
- R5: At each decision, the code rises by 1 if D > deadband, falls by 1 if D < -deadband, and otherwise holds. deadband is an unsigned input.
- R6: The code saturates at 63 and at 0 and never wraps.
- R7: `upd_o` is a one-cycle pulse in the first cycle that shows the decided code, once per window. The code changes in no other cycle.
- R8: Rest lasts max(rest_len,1) cycles. During rest `busy_o` is 0, the code is stable, and samples have no effect on any later decision, apart from advancing the A/B alternation.
- R9: The compute/decide/rest cycle repeats indefinitely. Each compute phase starts from a cleared detector with no carried-over partner samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SMP_W (10) | Signed sample, channel alternating per strobe |
| rest_len | input | REST_W (24) | Rest phase length in cycles |
| deadband | input | DB_W (32) | Unsigned detector magnitude below which the code holds |
| code_o | output | CODE_W (6) | Registered delay-line control code |
| busy_o | output | 1 | High during compute and decision |
| upd_o | output | 1 | One-cycle pulse when the code register is written |

## Verification
The assertions assume that `rest_len` and `deadband` change only while the block rests or is in reset, and that the sample stream truly alternates channels on every strobe. The stimulus sets both controls only between windows. It takes channel identity purely from the strobe count and drives only in-range 10-bit values. Random and gapped streams are mixed with full-scale constants, an exact deadband boundary, a zero-length rest, and long monotone runs that push the code into both rails.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {
    PH_COMPUTE = 2'd0,
    PH_DECIDE  = 2'd1,
    PH_REST    = 2'd2
  } phase_t;
endpackage

// File: rtl/skew_pair.sv
module skew_pair #(
  parameter int SMP_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        vld,
  input  logic                        en,
  input  logic                        clr,
  input  logic signed [SMP_W-1:0]     x,
  output logic signed [2*SMP_W-1:0]   prod,
  output logic                        prod_vld,
  output logic                        prod_sub
);
  // is_b: the next strobed sample belongs to channel B
  logic                    is_b;
  logic signed [SMP_W-1:0] last_a, last_b, partner;
  logic                    has_a, has_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_b   <= 1'b0;
      last_a <= '0;
      last_b <= '0;
      has_a  <= 1'b0;
      has_b  <= 1'b0;
    end else begin
      if (vld) is_b <= ~is_b;
      if (clr) begin
        has_a <= 1'b0;
        has_b <= 1'b0;
      end else if (en && vld) begin
        if (is_b) begin
          last_b <= x;
          has_b  <= 1'b1;
        end else begin
          last_a <= x;
          has_a  <= 1'b1;
        end
      end
    end
  end

  assign partner  = is_b ? last_a : last_b;
  assign prod     = partner * x;
  assign prod_vld = en && vld && (is_b ? has_a : has_b);
  assign prod_sub = ~is_b;
endmodule

// File: rtl/skew_acc.sv
module skew_acc #(
  parameter int PROD_W = 20,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     pv,
  input  logic                     sub,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [ACC_W-1:0]  acc
);
  logic signed [ACC_W-1:0] ext;
  assign ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (pv)    acc <= sub ? acc - ext : acc + ext;
  end
endmodule

// File: rtl/skew_sched.sv
module skew_sched
  import skew_pkg::*;
#(
  parameter int WIN_LEN = 8000,
  parameter int REST_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [REST_W-1:0] rest_len,
  output phase_t            phase,
  output logic              en,
  output logic              clr,
  output logic              decide
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [CNT_W-1:0]  cnt;
  logic [REST_W-1:0] rcnt;
  logic              leave;

  assign leave  = (phase == PH_REST) &&
                  (({1'b0, rcnt} + 1'b1) >= {1'b0, rest_len});
  assign en     = (phase == PH_COMPUTE);
  assign decide = (phase == PH_DECIDE);
  assign clr    = leave;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_COMPUTE;
      cnt   <= '0;
      rcnt  <= '0;
    end else begin
      case (phase)
        PH_COMPUTE: if (vld) begin
          if (cnt == CNT_W'(WIN_LEN - 1)) begin
            cnt   <= '0;
            phase <= PH_DECIDE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DECIDE: begin
          rcnt  <= '0;
          phase <= PH_REST;
        end
        PH_REST: begin
          if (leave) phase <= PH_COMPUTE;
          else       rcnt  <= rcnt + 1'b1;
        end
        default: phase <= PH_COMPUTE;
      endcase
    end
  end
endmodule

// File: rtl/skew_code.sv
module skew_code #(
  parameter int CODE_W   = 6,
  parameter int CODE_RST = 32,
  parameter int ACC_W    = 34,
  parameter int DB_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    decide,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [DB_W-1:0]         deadband,
  output logic [CODE_W-1:0]       code,
  output logic                    upd
);
  localparam int CMP_W = ((ACC_W > DB_W) ? ACC_W : DB_W) + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic signed [CMP_W-1:0] acc_x, db_x;
  logic                    go_up, go_dn;

  assign acc_x = {{(CMP_W-ACC_W){acc[ACC_W-1]}}, acc};
  assign db_x  = {{(CMP_W-DB_W){1'b0}}, deadband};
  assign go_up = acc_x > db_x;
  assign go_dn = acc_x < -db_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CODE_W'(CODE_RST);
      upd  <= 1'b0;
    end else begin
      upd <= decide;
      if (decide) begin
        if (go_up && code != CODE_MAX)      code <= code + 1'b1;
        else if (go_dn && code != '0)       code <= code - 1'b1;
      end
    end
  end
endmodule

// File: rtl/skew_cal_ctrl.sv
module skew_cal_ctrl
  import skew_pkg::*;
#(
  parameter int SMP_W    = 10,
  parameter int CODE_W   = 6,
  parameter int CODE_RST = 32,
  parameter int WIN_LEN  = 8000,
  parameter int REST_W   = 24,
  parameter int DB_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic [REST_W-1:0]       rest_len,
  input  logic [DB_W-1:0]         deadband,
  output logic [CODE_W-1:0]       code_o,
  output logic                    busy_o,
  output logic                    upd_o
);
  localparam int PROD_W = 2 * SMP_W;
  localparam int ACC_W  = PROD_W + $clog2(WIN_LEN) + 1;

  phase_t                   phase;
  logic                     en, clr, decide;
  logic signed [PROD_W-1:0] prod;
  logic                     prod_vld, prod_sub;
  logic signed [ACC_W-1:0]  acc_q;

  skew_sched #(.WIN_LEN(WIN_LEN), .REST_W(REST_W)) u_sched (
    .clk(clk), .rst(rst), .vld(smp_vld), .rest_len(rest_len),
    .phase(phase), .en(en), .clr(clr), .decide(decide)
  );

  skew_pair #(.SMP_W(SMP_W)) u_pair (
    .clk(clk), .rst(rst), .vld(smp_vld), .en(en), .clr(clr), .x(smp_data),
    .prod(prod), .prod_vld(prod_vld), .prod_sub(prod_sub)
  );

  skew_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .pv(prod_vld), .sub(prod_sub),
    .prod(prod), .acc(acc_q)
  );

  skew_code #(.CODE_W(CODE_W), .CODE_RST(CODE_RST), .ACC_W(ACC_W),
              .DB_W(DB_W)) u_code (
    .clk(clk), .rst(rst), .decide(decide), .acc(acc_q),
    .deadband(deadband), .code(code_o), .upd(upd_o)
  );

  assign busy_o = (phase != PH_REST);
endmodule

// File: rtl/skew_cal_chk.sv
module skew_cal_chk #(
  parameter int SMP_W   = 10,
  parameter int CODE_W  = 6,
  parameter int WIN_LEN = 8000,
  parameter int ACC_W   = 34
) (
  input logic                    clk,
  input logic                    rst,
  input logic [CODE_W-1:0]       code,
  input logic                    busy,
  input logic                    upd,
  input logic signed [ACC_W-1:0] acc
);
  localparam longint ACC_LIM = longint'(WIN_LEN) <<< (2 * SMP_W - 2);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (longint'(acc) <= ACC_LIM) && (longint'(acc) >= -ACC_LIM));

  p_busy_end_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> upd);

  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |->
      (({1'b0, code} == {1'b0, $past(code)} + 1'b1) ||
       ({1'b0, code} + 1'b1 == {1'b0, $past(code)})));

  p_upd_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);

  p_code_on_upd_r7: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> upd);

  p_upd_in_rest_r7: assert property (@(posedge clk) disable iff (rst)
    upd |-> !busy);

  p_rest_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(code));
endmodule

bind skew_cal_ctrl skew_cal_chk #(
  .SMP_W(SMP_W), .CODE_W(CODE_W), .WIN_LEN(WIN_LEN), .ACC_W(ACC_W)
) i_chk (
  .clk(clk), .rst(rst), .code(code_o), .busy(busy_o), .upd(upd_o), .acc(acc_q)
);

// File: tb/test_skew_cal_ctrl.sv
module test_skew_cal_ctrl;
  localparam int SMP_W  = 10;
  localparam int CODE_W = 6;
  localparam int WIN    = 64;
  localparam int REST_W = 16;
  localparam int DB_W   = 32;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    smp_vld = 1'b0;
  logic signed [SMP_W-1:0] smp_data = '0;
  logic [REST_W-1:0]       rest_len = 16'd20;
  logic [DB_W-1:0]         deadband = '0;
  logic [CODE_W-1:0]       code_o;
  logic                    busy_o, upd_o;

  skew_cal_ctrl #(.SMP_W(SMP_W), .CODE_W(CODE_W), .WIN_LEN(WIN),
                  .REST_W(REST_W), .DB_W(DB_W)) i_skew_cal_ctrl (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .rest_len(rest_len), .deadband(deadband),
    .code_o(code_o), .busy_o(busy_o), .upd_o(upd_o)
  );

  always #5 clk = ~clk;

  int     n_chk = 0, n_fail = 0;
  longint nsent = 0;
  int     exp_code = 32;
  logic signed [SMP_W-1:0] win_s [WIN];

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint detect(input bit a_first);
    longint d = 0;
    for (int i = 1; i < WIN; i++) begin
      bit     prev_a = a_first ^ ((i - 1) % 2 == 1);
      longint p = longint'(win_s[i-1]) * longint'(win_s[i]);
      if (prev_a) d += p;
      else        d -= p;
    end
    return d;
  endfunction

  function automatic int step(input int c, input longint d, input longint db);
    if (d > db && c < 63)  return c + 1;
    if (d < -db && c > 0)  return c - 1;
    return c;
  endfunction

  // one compute window followed by its rest phase
  task automatic run_window(input bit gaps, input int junk, input string req);
    bit     a_first;
    longint d;
    int     w, rc, jl;
    bit     frozen;
    w = 0;
    while (!busy_o && w < 1000) begin @(negedge clk); w++; end
    a_first = (nsent % 2 == 0);
    for (int i = 0; i < WIN; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); smp_vld = 1'b0;
      end
      @(negedge clk);
      smp_vld = 1'b1; smp_data = win_s[i]; nsent++;
    end
    @(negedge clk); smp_vld = 1'b0;
    d = detect(a_first);
    exp_code = step(exp_code, d, longint'(deadband));
    w = 0;
    while (!upd_o && w < 20) begin @(negedge clk); w++; end
    chk(upd_o == 1'b1, {"R7 upd pulse ", req}, upd_o, 1);
    chk(code_o == exp_code, {"R5 code ", req}, code_o, exp_code);
    chk(busy_o == 1'b0, "R4 busy low at decision", busy_o, 0);
    rc = 0; jl = junk; frozen = 1'b1;
    while (!busy_o && rc < 100000) begin
      if (rc == 1) chk(upd_o == 1'b0, "R7 upd one cycle", upd_o, 0);
      if (code_o != exp_code) frozen = 1'b0;
      rc++;
      if (jl > 0) begin
        smp_vld = 1'b1; smp_data = SMP_W'($urandom); nsent++; jl--;
      end else begin
        smp_vld = 1'b0;
      end
      @(negedge clk);
    end
    smp_vld = 1'b0;
    chk(frozen, "R8 code frozen in rest", code_o, exp_code);
    chk(rc == ((rest_len == 0) ? 1 : int'(rest_len)), "R8 rest length", rc,
        (rest_len == 0) ? 1 : int'(rest_len));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int edge_a;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(code_o == 32, "R1 reset code", code_o, 32);
    rst = 1'b0;
    @(negedge clk);
    chk(code_o == 32, "R1 code after reset", code_o, 32);
    chk(busy_o == 1'b1, "R1 busy after reset", busy_o, 1);
    chk(upd_o == 1'b0, "R1 upd after reset", upd_o, 0);

    // R2 random streams, with and without strobe gaps (R4)
    for (int k = 0; k < 4; k++) begin
      foreach (win_s[i]) win_s[i] = SMP_W'($urandom);
      run_window(k[0], $urandom % 4, "R2 random");
    end

    // R3 full-scale streams
    foreach (win_s[i]) win_s[i] = -10'sd512;
    run_window(1'b0, 1, "R3 all -512");
    foreach (win_s[i]) win_s[i] = i[0] ? -10'sd512 : 10'sd511;
    run_window(1'b0, 2, "R3 alternating full scale");

    // R5 deadband boundary: single pair 37 x -53, magnitude 1961
    foreach (win_s[i]) win_s[i] = '0;
    win_s[0] = 10'sd37; win_s[1] = -10'sd53;
    deadband = 32'd1961;
    run_window(1'b0, 0, "R5 at deadband holds");
    deadband = 32'd1960;
    run_window(1'b0, 3, "R5 just past deadband");
    deadband = 32'hFFFF_FFFF;
    foreach (win_s[i]) win_s[i] = SMP_W'($urandom);
    run_window(1'b0, 0, "R5 huge deadband");
    deadband = '0;

    // R8 zero rest length gives a single rest cycle
    rest_len = '0;
    foreach (win_s[i]) win_s[i] = SMP_W'($urandom);
    run_window(1'b1, 0, "R8 zero rest");
    rest_len = 16'd12;

    // R6 drive into one rail, then the other; R9 repeated windows
    foreach (win_s[i]) win_s[i] = 10'sd100;
    for (int k = 0; k < 40; k++) run_window(1'b0, 2, "R6 run one way");
    edge_a = code_o;
    chk(edge_a == 0 || edge_a == 63, "R6 first rail", edge_a, 63);
    foreach (win_s[i]) win_s[i] = i[0] ? -10'sd100 : 10'sd100;
    for (int k = 0; k < 70; k++) run_window(1'b0, 2, "R9 repeated");
    chk(int'(code_o) == 63 - edge_a, "R6 opposite rail", code_o, 63 - edge_a);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule